// File: doc/BRIEF.md
# DMX512 Frame Transmitter Engine

This block drives a single serial line with an endless stream of lighting-control frames. Each frame opens with a timed low period on the line (the break), then a timed high period (mark after break), then a null start character, then one character per channel slot read in ascending address order from an internal slot store, and finally a timed high idle (mark before break) before the next break begins. Characters are asynchronous: a low start bit, eight data bits least significant first and two high stop bits, each bit lasting a parameterised number of system clocks (64 clocks at a 16 MHz clock, which gives 250 kbaud).

A host updates channel levels at any time through a simple write port (address, byte, write enable). The slot store is cleared by reset. All frame timing is counted in microseconds from a tick that is derived from the system clock. The tick is restarted on every timed interval, so each interval lasts an exact number of clocks. For observation, the block raises `frame_start` in the first cycle of each break and shows on `slot_index` the address of the slot that is being sent.

Top module: `dmx_frame_tx`

## Requirements
- R1: Each frame starts with a break. `dmx_out` is held low for exactly BREAK_US*CLK_PER_US clocks, and `frame_start` is high only in the first of those clocks.
- R2: After the break, `dmx_out` stays high for exactly MAB_US*CLK_PER_US clocks. The start bit of the first character follows directly.
- R3: The first character of every frame carries the value 0x00.
- R4: Every character is 11 bit periods of CLK_PER_BIT clocks each: one start bit at 0, then data bits 0 to 7 (least significant first), then two stop bits at 1.
- R5: After the start character come exactly NUM_SLOTS characters, holding the slot store contents at addresses 0, 1, ... NUM_SLOTS-1 in that order. While the character for address k is being sent, `slot_index` equals k.
- R6: The start bits of consecutive characters in a frame fall exactly SLOT_US*CLK_PER_US clocks apart. SLOT_US*CLK_PER_US must be at least 11*CLK_PER_BIT.
- R7: The next break begins (SLOT_US+MBB_US)*CLK_PER_US clocks after the start bit of the last slot. The line is high between that character and the break, and frames repeat without end.
- R8: Reset clears every slot to 0x00 and puts the block in the break. While reset is applied, `dmx_out` is 0, `frame_start` is 1 and `slot_index` is 0. The first frame after reset therefore carries only zero slots.
- R9: A host write stores `wr_data` at `wr_addr` in the cycle that `wr_en` is high. A slot that is written while its frame is being sent is transmitted as either the old byte or the new byte, never a mixture. Every write is visible in the next frame that starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | AW = clog2(NUM_SLOTS) | Slot address to write |
| wr_data | input | 8 | Channel level to store |
| dmx_out | output | 1 | Serial line, idle high |
| frame_start | output | 1 | High in the first clock of each break |
| slot_index | output | AW | Address of the slot being sent |

## Verification
The assertions assume that the host writes only addresses below NUM_SLOTS. They also assume that the parameters leave a slot interval at least as long as one 11-bit character, so the sequencer never loads the serializer while it is busy. The bench writes only in-range addresses and uses scaled timing parameters (2 clocks per microsecond, 8 clocks per bit, a 48 µs slot interval, 8 slots) that meet this relation. Within those limits the bench decodes the line at the middle of each bit, measures the break, mark and spacing lengths, and hammers one slot with writes while a frame is being sent.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   // Sequencer phases; the encoding also fixes the reset phase (break).
   typedef enum logic [1:0] {
      ST_MBB   = 2'd0,
      ST_DATA  = 2'd1,
      ST_MAB   = 2'd2,
      ST_BREAK = 2'd3
   } seq_state_t;

   localparam logic [7:0] START_CODE = 8'h00;
   // start + 8 data + 2 stop
   localparam int CHAR_BITS  = 11;
   localparam int TIMER_W    = 16;

endpackage

// File: rtl/dmx_us_tick.sv
module dmx_us_tick #(
   parameter int CLK_PER_US = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = (cnt == LAST);

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R1

endmodule

// File: rtl/dmx_slot_mem.sv
module dmx_slot_mem #(
   parameter int DEPTH = 512,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [7:0]    wd,
   input  logic [AW-1:0] ra,
   output logic [7:0]    rd
);
   logic [7:0] mem [DEPTH];

   // Whole-byte storage with a registered read that refreshes every cycle:
   // a byte read for sending is either the value before or after a write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
         rd <= '0;
      end else begin
         if (we) begin
            mem[wa] <= wd;
         end
         rd <= mem[ra];
      end
   end

   AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(wa) < DEPTH)); // R9

endmodule

// File: rtl/dmx_char_tx.sv
module dmx_char_tx
   import dmx_pkg::*;
#(
   parameter int CLK_PER_BIT = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] data,
   output logic       busy,
   output logic       tx
);
   localparam int BW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
   localparam logic [BW-1:0] LASTB = BW'(CLK_PER_BIT - 1);
   localparam logic [3:0] REST_BITS = 4'(CHAR_BITS - 1);

   logic [BW-1:0] cnt;
   logic [3:0]    left;
   logic [9:0]    sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tx   <= 1'b1;
         cnt  <= '0;
         left <= '0;
         sh   <= '1;
      end else if (load) begin
         busy <= 1'b1;
         tx   <= 1'b0;
         sh   <= {2'b11, data};
         cnt  <= '0;
         left <= REST_BITS;
      end else if (busy) begin
         if (cnt == LASTB) begin
            cnt <= '0;
            if (left == 4'd0) begin
               busy <= 1'b0;
            end else begin
               tx   <= sh[0];
               sh   <= {1'b1, sh[9:1]};
               left <= left - 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy); // R6
   AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tx); // R4
   AST_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> tx); // R4

endmodule

// File: rtl/dmx_frame_seq.sv
module dmx_frame_seq
   import dmx_pkg::*;
#(
   parameter int NUM_SLOTS = 512,
   parameter int AW        = 9,
   parameter int BREAK_US  = 100,
   parameter int MAB_US    = 100,
   parameter int MBB_US    = 100,
   parameter int SLOT_US   = 60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic          tick_clr,
   input  logic          char_busy,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          char_load,
   output logic [7:0]    char_data,
   output logic          in_break,
   output logic          frame_start,
   output logic [AW-1:0] slot_index
);
   localparam int SW = $clog2(NUM_SLOTS + 1);
   localparam logic [SW-1:0] SENT_ALL = SW'(NUM_SLOTS);
   localparam logic [TIMER_W-1:0] T_BREAK = TIMER_W'(BREAK_US);
   localparam logic [TIMER_W-1:0] T_MAB   = TIMER_W'(MAB_US);
   localparam logic [TIMER_W-1:0] T_MBB   = TIMER_W'(MBB_US);
   localparam logic [TIMER_W-1:0] T_SLOT  = TIMER_W'(SLOT_US);

   seq_state_t           state, nxt;
   logic [TIMER_W-1:0]   us_left, load_us;
   logic [SW-1:0]        sent;
   logic [AW-1:0]        slot_q;
   logic                 fresh, restart, expired, send_slot;

   assign expired = (us_left == '0) || (tick && us_left == TIMER_W'(1));

   always_comb begin
      nxt       = state;
      restart   = 1'b0;
      load_us   = '0;
      char_load = 1'b0;
      char_data = rd_data;
      send_slot = 1'b0;
      unique case (state)
         ST_BREAK: if (expired) begin
            nxt     = ST_MAB;
            restart = 1'b1;
            load_us = T_MAB;
         end
         ST_MAB: if (expired) begin
            nxt       = ST_DATA;
            restart   = 1'b1;
            load_us   = T_SLOT;
            char_load = 1'b1;
            char_data = START_CODE;
         end
         ST_DATA: if (expired && !char_busy) begin
            restart = 1'b1;
            if (sent == SENT_ALL) begin
               nxt     = ST_MBB;
               load_us = T_MBB;
            end else begin
               load_us   = T_SLOT;
               char_load = 1'b1;
               send_slot = 1'b1;
            end
         end
         ST_MBB: if (expired) begin
            nxt     = ST_BREAK;
            restart = 1'b1;
            load_us = T_BREAK;
         end
         default: nxt = ST_BREAK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_BREAK;
         fresh   <= 1'b1;
         us_left <= T_BREAK;
         sent    <= '0;
         slot_q  <= '0;
      end else begin
         state <= nxt;
         fresh <= (nxt != state);
         if (restart) begin
            us_left <= load_us;
         end else if (tick && us_left != '0) begin
            us_left <= us_left - 1'b1;
         end
         if (state == ST_MAB && expired) begin
            sent <= '0;
         end else if (send_slot) begin
            sent   <= sent + 1'b1;
            slot_q <= sent[AW-1:0];
         end
      end
   end

   assign tick_clr    = restart;
   assign rd_addr     = sent[AW-1:0];
   assign in_break    = (state == ST_BREAK);
   assign frame_start = fresh && (state == ST_BREAK);
   assign slot_index  = slot_q;

   AST_FRAME_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start); // R1
   AST_MAB_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MAB && $past(state) != ST_MAB) |-> $past(state) == ST_BREAK); // R2
   AST_MAB_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MAB) |-> !char_busy); // R2
   AST_SLOT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sent <= SENT_ALL); // R5
   AST_MBB_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MBB && $past(state) == ST_DATA) |-> sent == SENT_ALL); // R7

endmodule

// File: rtl/dmx_frame_tx.sv
module dmx_frame_tx #(
   parameter int CLK_PER_US  = 16,
   parameter int CLK_PER_BIT = 64,
   parameter int NUM_SLOTS   = 512,
   parameter int BREAK_US    = 100,
   parameter int MAB_US      = 100,
   parameter int MBB_US      = 100,
   parameter int SLOT_US     = 60,
   localparam int AW         = $clog2(NUM_SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   output logic          dmx_out,
   output logic          frame_start,
   output logic [AW-1:0] slot_index
);
   import dmx_pkg::*;

   initial begin
      AST_PARAM_TICK: assert (CLK_PER_US >= 2 && CLK_PER_BIT >= 2); // R4
      AST_PARAM_SLOTS: assert (NUM_SLOTS >= 2); // R5
      AST_PARAM_SPACING: assert (SLOT_US * CLK_PER_US >= CHAR_BITS * CLK_PER_BIT); // R6
      AST_PARAM_TIMES: assert (BREAK_US >= 1 && MAB_US >= 1 && MBB_US >= 1 &&
                               SLOT_US < 65536 && BREAK_US < 65536 &&
                               MAB_US < 65536 && MBB_US < 65536); // R7
   end

   logic          tick, tick_clr, char_busy, char_load, char_tx, in_break;
   logic [7:0]    rd_data, char_data;
   logic [AW-1:0] rd_addr;

   dmx_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tick_clr),
      .tick  (tick)
   );

   dmx_slot_mem #(.DEPTH(NUM_SLOTS), .AW(AW)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .wa    (wr_addr),
      .wd    (wr_data),
      .ra    (rd_addr),
      .rd    (rd_data)
   );

   dmx_frame_seq #(
      .NUM_SLOTS (NUM_SLOTS),
      .AW        (AW),
      .BREAK_US  (BREAK_US),
      .MAB_US    (MAB_US),
      .MBB_US    (MBB_US),
      .SLOT_US   (SLOT_US)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .tick_clr    (tick_clr),
      .char_busy   (char_busy),
      .rd_data     (rd_data),
      .rd_addr     (rd_addr),
      .char_load   (char_load),
      .char_data   (char_data),
      .in_break    (in_break),
      .frame_start (frame_start),
      .slot_index  (slot_index)
   );

   dmx_char_tx #(.CLK_PER_BIT(CLK_PER_BIT)) u_char (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (char_load),
      .data  (char_data),
      .busy  (char_busy),
      .tx    (char_tx)
   );

   assign dmx_out = char_tx & ~in_break;

   AST_BREAK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !dmx_out); // R1

endmodule

// File: tb/dmx_frame_tx_tb.sv
module dmx_frame_tx_tb;
   localparam int CPU  = 2;
   localparam int CPB  = 8;
   localparam int NS   = 8;
   localparam int BRK  = 20;
   localparam int MAB  = 12;
   localparam int MBB  = 16;
   localparam int SLT  = 48;
   localparam int AW   = $clog2(NS);
   localparam int NVEC = 10;
   // {addr, data} pairs written in order; later entries overwrite earlier ones
   localparam logic [15:0] VEC [NVEC] = '{
      16'h00A5, 16'h015A, 16'h02FF, 16'h0301, 16'h0480,
      16'h0500, 16'h067E, 16'h07C3, 16'h0233, 16'h0781
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic          dmx_out, frame_start;
   logic [AW-1:0] slot_index;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   logic [7:0] exp_mem [NS];
   logic [7:0] rx      [NS+1];
   int         fall_t  [NS+1];
   int         idx_seen[NS+1];
   bit         fmt_ok  [NS+1];
   int         brk_len, mab_len, mbb_gap;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dmx_frame_tx #(
      .CLK_PER_US (CPU), .CLK_PER_BIT(CPB), .NUM_SLOTS(NS),
      .BREAK_US   (BRK), .MAB_US(MAB), .MBB_US(MBB), .SLOT_US(SLT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .dmx_out(dmx_out), .frame_start(frame_start),
      .slot_index(slot_index)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Called at a negedge; returns at the negedge one cycle later.
   task automatic do_write(input int a, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Called at a negedge; returns at the negedge showing the next frame_start.
   task automatic capture_frame();
      int f;
      logic [10:0] bits;
      while (!frame_start) @(negedge clk);
      brk_len = 0;
      while (!dmx_out) begin brk_len++; @(negedge clk); end
      mab_len = 0;
      while (dmx_out) begin mab_len++; @(negedge clk); end
      for (int c = 0; c <= NS; c++) begin
         if (c > 0) while (dmx_out) @(negedge clk);
         f = cyc;
         fall_t[c] = f;
         for (int k = 0; k < 11; k++) begin
            while (cyc != f + CPB/2 + k*CPB) @(negedge clk);
            bits[k] = dmx_out;
            if (k == 0) idx_seen[c] = int'(slot_index);
         end
         rx[c]     = bits[8:1];
         fmt_ok[c] = (bits[0] == 1'b0) && (bits[10:9] == 2'b11);
      end
      while (!frame_start) @(negedge clk);
      mbb_gap = cyc - fall_t[NS];
   endtask

   task automatic check_timing();
      check(brk_len == BRK*CPU, "R1", "break length", brk_len, BRK*CPU);
      check(mab_len == MAB*CPU, "R2", "mark after break", mab_len, MAB*CPU);
      check(rx[0] == 8'h00, "R3", "start code", int'(rx[0]), 0);
      for (int c = 0; c <= NS; c++)
         check(fmt_ok[c], "R4", "start/stop bits", int'(fmt_ok[c]), 1);
      for (int c = 1; c <= NS; c++) begin
         check(idx_seen[c] == c-1, "R5", "slot_index", idx_seen[c], c-1);
         check(fall_t[c] - fall_t[c-1] == SLT*CPU, "R6", "slot spacing",
               fall_t[c] - fall_t[c-1], SLT*CPU);
      end
      check(mbb_gap == (SLT+MBB)*CPU, "R7", "last slot to next break",
            mbb_gap, (SLT+MBB)*CPU);
   endtask

   task automatic check_data(input string req, input int skip);
      for (int c = 1; c <= NS; c++)
         if (c-1 != skip)
            check(rx[c] == exp_mem[c-1], req, "slot data", int'(rx[c]),
                  int'(exp_mem[c-1]));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NS; i++) exp_mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(dmx_out == 1'b0, "R8", "dmx_out in reset", int'(dmx_out), 0);
      check(frame_start == 1'b1, "R8", "frame_start in reset", int'(frame_start), 1);
      check(slot_index == '0, "R8", "slot_index in reset", int'(slot_index), 0);

      // Fill the store, then reset again: R8 requires it to be cleared.
      rst_n = 1'b1;
      for (int i = 0; i < NS; i++) do_write(i, 8'hFF);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      capture_frame();
      check_timing();
      check_data("R8", -1);

      // Back-to-back frame (R7 repetition), still all zero
      capture_frame();
      check_timing();
      check_data("R7", -1);

      // Vector table walk: writes, then the next frame must carry them (R9/R5)
      for (int v = 0; v < NVEC; v++) begin
         do_write(int'(VEC[v][8 +: AW]), VEC[v][7:0]);
         exp_mem[VEC[v][8 +: AW]] = VEC[v][7:0];
      end
      capture_frame();
      check_timing();
      check_data("R5", -1);

      // R9: hammer slot 3 with alternating values during a whole frame
      fork
         capture_frame();
         begin
            for (int n = 0; n < 900; n++) do_write(3, n[0] ? 8'hC3 : 8'h3C);
         end
      join
      check(rx[4] == 8'h3C || rx[4] == 8'hC3, "R9", "slot 3 under writes",
            int'(rx[4]), 8'h3C);
      check_data("R9", 3);
      exp_mem[3] = 8'hC3;

      // R9: write a slot already sent; old value now, new value next frame
      fork
         capture_frame();
         begin
            repeat (700) @(negedge clk);
            do_write(0, 8'h99);
         end
      join
      check_data("R9", -1);
      exp_mem[0] = 8'h99;
      capture_frame();
      check_timing();
      check_data("R9", -1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule